// File: doc/BRIEF.md
# Pixel-Doubled Monochrome Raster Display

This block drives a 640x480 analog-style raster from a small one-bit-per-pixel picture of 320x240. Each stored pixel is shown as a 2x2 square of screen pixels, so the stored picture fills the whole visible area. The stored picture is byte-organised. Every byte holds eight horizontally adjacent stored pixels, and the leftmost of them sits in bit 7. A row of the picture is 40 bytes long, and the whole picture is 9600 bytes.

The block runs on a 50 MHz system clock. An internal enable that fires on every second system clock gives a pixel rate of about 25 MHz. The raster is 800 pixel periods per line and 525 lines per frame. The scan reads one stored byte for each pixel period from a synchronous store and picks one bit of it. That bit is copied onto all three colour outputs, so each pixel is either white or black. The sync pulses are delayed by the same amount as the pixel data, so they stay aligned with it.

An external feeder loads the picture through a plain byte-write port on the system clock. The port has no back-pressure: every write with the enable high is taken in the cycle it is presented, and the port has no ready signal. Writes may arrive at any time, including while the scan is reading.

Top module: `mono_fb_display`

## Requirements
- R1: A line lasts H_VIS+H_FP+H_SYNC+H_BP pixel periods (640+16+96+48 by default). `hsync_n` is low exactly for pixel columns H_VIS+H_FP up to H_VIS+H_FP+H_SYNC-1.
- R2: A frame lasts V_VIS+V_FP+V_SYNC+V_BP lines (480+10+2+33 by default). `vsync_n` is low exactly for rows V_VIS+V_FP up to V_VIS+V_FP+V_SYNC-1.
- R3: `rgb_o` is 3'b000 for every pixel whose column is H_VIS or more, or whose row is V_VIS or more.
- R4: The visible pixel at (col,row) reads stored byte (row>>1)*(H_VIS/16)+(col>>4). Each stored pixel therefore covers two columns and two rows.
- R5: Within that byte, the bit used is 7-((col>>1) mod 8). The leftmost stored pixel of a byte is bit 7.
- R6: For a visible pixel, all three `rgb_o` bits equal the selected stored bit. They appear in the same pixel period as that pixel's sync values.
- R7: The outputs change at most once every two system clocks. Each pixel's values are held for two consecutive system clocks.
- R8: A write with `wr_en` high stores `wr_data` at byte `wr_addr` when `wr_addr` is below (H_VIS/16)*(V_VIS/2). Any other write changes no stored byte.
- R9: If a write lands on the stored word being read in the same clock, the scan receives the contents from before the write. The written value shows from the next read onward.
- R10: While `rst_n` is low and up to the first pixel period after it, the outputs are idle: both syncs are high and `rgb_o` is 0. The first pixel shown after reset is column 0, row 0, and it appears two system clocks after release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, twice the pixel rate |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Byte write strobe, always accepted |
| wr_addr | input | ADDR_W (14) | Byte address in the stored picture |
| wr_data | input | 8 | Eight pixels, leftmost in bit 7 |
| hsync_n | output | 1 | Horizontal sync, active low |
| vsync_n | output | 1 | Vertical sync, active low |
| rgb_o | output | 3 | Colour; all bits equal, forced to 0 in blanking |

## Verification
The feeder's write and the scan's read can hit the same stored word in the same clock. The bench provokes this by timing a write, from its own count of clocks since reset, to the exact pixel period in which the scan reads the first column of one byte. That write inverts the byte. The bench expects the old bit on that column and the new bit on the next column, which uses the same stored pixel but is read one period later. Out-of-range writes are also issued during the scan, at addresses whose low bits alias displayed bytes. The bench confirms they leave the picture unchanged.

// File: rtl/mono_fb_pkg.sv
package mono_fb_pkg;
  // Per-pixel raster qualifiers carried alongside the pixel data.
  typedef struct packed {
    logic vis;   // inside the visible window
    logic hs_n;  // horizontal sync, active low
    logic vs_n;  // vertical sync, active low
  } beam_t;

  localparam int PIX_PER_BYTE = 8;
  // Screen columns covered by one stored byte (8 pixels, each doubled).
  localparam int COLS_PER_BYTE = 2 * PIX_PER_BYTE;
endpackage

// File: rtl/fbd_raster_timer.sv
module fbd_raster_timer
  import mono_fb_pkg::*;
#(
  parameter int H_VIS   = 640,
  parameter int H_FP    = 16,
  parameter int H_SYNC  = 96,
  parameter int H_BP    = 48,
  parameter int V_VIS   = 480,
  parameter int V_FP    = 10,
  parameter int V_SYNC  = 2,
  parameter int V_BP    = 33,
  parameter int COORD_W = 10
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               adv,
  output logic [COORD_W-1:0] col,
  output logic [COORD_W-1:0] row,
  output beam_t              beam
);
  localparam int H_TOTAL = H_VIS + H_FP + H_SYNC + H_BP;
  localparam int V_TOTAL = V_VIS + V_FP + V_SYNC + V_BP;
  localparam int HS_BEG  = H_VIS + H_FP;
  localparam int HS_END  = HS_BEG + H_SYNC;
  localparam int VS_BEG  = V_VIS + V_FP;
  localparam int VS_END  = VS_BEG + V_SYNC;

  logic line_end, frame_end;
  assign line_end  = (col == COORD_W'(H_TOTAL - 1));
  assign frame_end = (row == COORD_W'(V_TOTAL - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      col <= '0;
      row <= '0;
    end else if (adv) begin
      if (line_end) begin
        col <= '0;
        row <= frame_end ? '0 : row + 1'b1;
      end else begin
        col <= col + 1'b1;
      end
    end
  end

  always_comb begin
    beam.vis  = (col < COORD_W'(H_VIS)) && (row < COORD_W'(V_VIS));
    beam.hs_n = !((col >= COORD_W'(HS_BEG)) && (col < COORD_W'(HS_END)));
    beam.vs_n = !((row >= COORD_W'(VS_BEG)) && (row < COORD_W'(VS_END)));
  end

  AST_COL_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && line_end) |=> (col == '0)); // R1

  AST_ROW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !line_end) |=> $stable(row)); // R2

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !adv |=> ($stable(col) && $stable(row))); // R7
endmodule

// File: rtl/fbd_addr_map.sv
module fbd_addr_map
  import mono_fb_pkg::*;
#(
  parameter int H_VIS   = 640,
  parameter int COORD_W = 10,
  parameter int ADDR_W  = 14
) (
  input  logic [COORD_W-1:0] col,
  input  logic [COORD_W-1:0] row,
  output logic [ADDR_W-1:0]  byte_addr,
  output logic [2:0]         bit_idx
);
  localparam int ROW_BYTES = H_VIS / COLS_PER_BYTE;
  localparam int PROD_W    = ADDR_W + COORD_W;

  logic [PROD_W-1:0] full_addr;

  always_comb begin
    full_addr = PROD_W'(row[COORD_W-1:1]) * PROD_W'(ROW_BYTES)
              + PROD_W'(col[COORD_W-1:4]);
    byte_addr = full_addr[ADDR_W-1:0];
    // leftmost doubled pixel of a byte sits in bit 7
    bit_idx   = ~col[3:1];
  end
endmodule

// File: rtl/fbd_frame_store.sv
module fbd_frame_store #(
  parameter int FB_BYTES = 9600,
  parameter int LANES    = 4,
  parameter int ADDR_W   = 14
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [7:0]        rd_byte
);
  localparam int LANE_W = $clog2(LANES);
  localparam int WORDS  = (FB_BYTES + LANES - 1) / LANES;
  localparam int WIDX_W = (WORDS > 1) ? $clog2(WORDS) : 1;

  logic [8*LANES-1:0] mem [WORDS];
  logic [8*LANES-1:0] rword;
  logic [LANE_W-1:0]  rlane;

  logic              wr_ok, rd_ok;
  logic [WIDX_W-1:0] widx, ridx;
  logic [LANE_W-1:0] wlane;

  always_comb begin
    wr_ok = wr_en && (wr_addr < ADDR_W'(FB_BYTES));
    rd_ok = rd_addr < ADDR_W'(FB_BYTES);
    widx  = WIDX_W'(wr_addr >> LANE_W);
    wlane = wr_addr[LANE_W-1:0];
    ridx  = rd_ok ? WIDX_W'(rd_addr >> LANE_W) : '0;
  end

  always_ff @(posedge clk) begin
    if (wr_ok) mem[widx][{wlane, 3'b000} +: 8] <= wr_data;
  end

  // read-first: a same-cycle write is not seen by this read
  always_ff @(posedge clk) begin
    if (rd_en) begin
      rword <= mem[ridx];
      rlane <= rd_addr[LANE_W-1:0];
    end
  end

  logic [7:0] lane_byte [LANES];
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign lane_byte[g] = rword[g*8 +: 8];
  end

  assign rd_byte = lane_byte[rlane];
endmodule

// File: rtl/mono_fb_display.sv
module mono_fb_display
  import mono_fb_pkg::*;
#(
  parameter int H_VIS   = 640,
  parameter int H_FP    = 16,
  parameter int H_SYNC  = 96,
  parameter int H_BP    = 48,
  parameter int V_VIS   = 480,
  parameter int V_FP    = 10,
  parameter int V_SYNC  = 2,
  parameter int V_BP    = 33,
  parameter int COORD_W = 10,
  parameter int ADDR_W  = 14,
  parameter int LANES   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  output logic              hsync_n,
  output logic              vsync_n,
  output logic [2:0]        rgb_o
);
  localparam int FB_BYTES = (H_VIS / COLS_PER_BYTE) * (V_VIS / 2);

  logic               ce_q;
  logic [COORD_W-1:0] col, row;
  beam_t              beam;
  logic [ADDR_W-1:0]  byte_addr;
  logic [2:0]         bit_idx, bit_q;
  logic               vis_q, hs_q, vs_q;
  logic [7:0]         rd_byte;

  // pixel enable: every second system clock
  always_ff @(posedge clk) begin
    if (!rst_n) ce_q <= 1'b0;
    else        ce_q <= ~ce_q;
  end

  fbd_raster_timer #(
    .H_VIS(H_VIS), .H_FP(H_FP), .H_SYNC(H_SYNC), .H_BP(H_BP),
    .V_VIS(V_VIS), .V_FP(V_FP), .V_SYNC(V_SYNC), .V_BP(V_BP),
    .COORD_W(COORD_W)
  ) u_timer (
    .clk(clk), .rst_n(rst_n), .adv(ce_q),
    .col(col), .row(row), .beam(beam)
  );

  fbd_addr_map #(
    .H_VIS(H_VIS), .COORD_W(COORD_W), .ADDR_W(ADDR_W)
  ) u_map (
    .col(col), .row(row), .byte_addr(byte_addr), .bit_idx(bit_idx)
  );

  fbd_frame_store #(
    .FB_BYTES(FB_BYTES), .LANES(LANES), .ADDR_W(ADDR_W)
  ) u_store (
    .clk(clk), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(ce_q), .rd_addr(byte_addr), .rd_byte(rd_byte)
  );

  // qualifiers ride one pixel period behind, matching the store latency
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vis_q <= 1'b0;
      hs_q  <= 1'b1;
      vs_q  <= 1'b1;
      bit_q <= '0;
    end else if (ce_q) begin
      vis_q <= beam.vis;
      hs_q  <= beam.hs_n;
      vs_q  <= beam.vs_n;
      bit_q <= bit_idx;
    end
  end

  assign hsync_n = hs_q;
  assign vsync_n = vs_q;
  assign rgb_o   = vis_q ? {3{rd_byte[bit_q]}} : 3'b000;

  AST_HBLANK_DARK: assert property (@(posedge clk) disable iff (!rst_n)
    !hsync_n |-> (rgb_o == 3'b000)); // R3

  AST_VBLANK_DARK: assert property (@(posedge clk) disable iff (!rst_n)
    !vsync_n |-> (rgb_o == 3'b000)); // R3

  AST_HOLD_OFF_CE: assert property (@(posedge clk) disable iff (!rst_n)
    !ce_q |=> ($stable(rgb_o) && $stable(hsync_n) && $stable(vsync_n))); // R7

  AST_ADDR_IN_FB: assert property (@(posedge clk) disable iff (!rst_n)
    (ce_q && beam.vis) |-> (byte_addr < ADDR_W'(FB_BYTES))); // R4
endmodule

// File: tb/tb_mono_fb_display.sv
module tb_mono_fb_display;
  localparam int CLK_PERIOD = 10;
  localparam int HV = 32, HF = 4, HS = 8, HB = 4;
  localparam int VV = 16, VF = 2, VS = 2, VB = 3;
  localparam int HT = HV + HF + HS + HB;
  localparam int VT = VV + VF + VS + VB;
  localparam int FT = HT * VT;
  localparam int BPR = HV / 16;
  localparam int FBB = BPR * (VV / 2);
  localparam int AW = 14;
  localparam int NEDGES = 2 * (3 * FT) + 2;
  // collision pixel: frame 1, row 5, column 16 (first column of byte 5)
  localparam int K_COL = FT + 5 * HT + 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_en = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [7:0]    wr_data = '0;
  wire           hsync_n, vsync_n;
  wire  [2:0]    rgb;

  always #(CLK_PERIOD / 2) clk = ~clk;

  mono_fb_display #(
    .H_VIS(HV), .H_FP(HF), .H_SYNC(HS), .H_BP(HB),
    .V_VIS(VV), .V_FP(VF), .V_SYNC(VS), .V_BP(VB),
    .COORD_W(10), .ADDR_W(AW), .LANES(4)
  ) dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .hsync_n(hsync_n), .vsync_n(vsync_n), .rgb_o(rgb)
  );

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;
  logic [7:0] shadow [FBB];

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: got %0d expected %0d", tag, what, act, exp);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      fails++;
      $display("FAIL R7 watchdog: got 0 expected 1 (run completed)");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic       p_we;
    logic [AW-1:0] p_addr;
    logic [7:0] p_data;
    logic       prev_hs, prev_vs;
    logic [2:0] prev_rgb;

    // R8: load the picture during reset, plus out-of-range writes
    for (int b = 0; b < FBB; b++) begin
      @(negedge clk);
      wr_en = 1'b1; wr_addr = AW'(b); wr_data = 8'((b * 37 + 11) & 255);
      shadow[b] = wr_data;
    end
    for (int j = 0; j < 3; j++) begin
      @(negedge clk);
      wr_en = 1'b1; wr_data = 8'hFF;
      wr_addr = (j == 0) ? AW'(FBB) : (j == 1) ? AW'(FBB + 7) : AW'(16383);
    end
    @(negedge clk);
    wr_en = 1'b0;
    @(negedge clk);
    // R10: idle outputs in reset
    check(hsync_n == 1'b1, "R10", "hsync_n in reset", hsync_n, 1);
    check(vsync_n == 1'b1, "R10", "vsync_n in reset", vsync_n, 1);
    check(rgb == 3'b000, "R10", "rgb in reset", rgb, 0);
    rst_n = 1'b1;
    p_we = 1'b0; p_addr = '0; p_data = '0;
    prev_hs = 1'b1; prev_vs = 1'b1; prev_rgb = '0;

    for (int i = 1; i <= NEDGES; i++) begin
      @(negedge clk);
      if (i == 1) begin
        check(hsync_n == 1'b1 && vsync_n == 1'b1 && rgb == 3'b000, "R10",
              "outputs idle one clock after release", {hsync_n, vsync_n, rgb}, 5'b11000);
      end else if ((i % 2) == 0) begin
        int k, c, r, ba, bi;
        bit vis, ehs, evs;
        logic [2:0] ergb;
        string tag;
        k = i / 2 - 1;
        c = k % HT;
        r = (k / HT) % VT;
        vis = (c < HV) && (r < VV);
        ehs = !((c >= HV + HF) && (c < HV + HF + HS));
        evs = !((r >= VV + VF) && (r < VV + VF + VS));
        ba = (r / 2) * BPR + (c / 16);                 // R4
        bi = 7 - ((c / 2) % 8);                        // R5
        ergb = vis ? {3{shadow[ba][bi]}} : 3'b000;     // R6
        if (k == K_COL || k == K_COL + 1) tag = "R9";
        else if (!vis) tag = "R3";
        else if (k >= FT && (ba == 0 || ba == FBB - 1 || ba == 7)) tag = "R8";
        else tag = "R6";
        check(hsync_n == ehs, "R1", $sformatf("hsync_n col=%0d row=%0d", c, r), hsync_n, ehs);
        check(vsync_n == evs, "R2", $sformatf("vsync_n col=%0d row=%0d", c, r), vsync_n, evs);
        check(rgb == ergb, tag,
              $sformatf("rgb (mapping R4 R5) col=%0d row=%0d", c, r), rgb, ergb);
        prev_hs = hsync_n; prev_vs = vsync_n; prev_rgb = rgb;
      end else begin
        check(hsync_n == prev_hs && vsync_n == prev_vs && rgb == prev_rgb, "R7",
              "outputs held for second clock", {hsync_n, vsync_n, rgb},
              {prev_hs, prev_vs, prev_rgb});
      end

      // write presented at edge i is now in the store
      if (p_we && p_addr < AW'(FBB)) shadow[p_addr] = p_data;

      // drive the write for edge i+1
      p_we = 1'b0;
      if (i + 1 == 2 * (K_COL + 1)) begin
        p_we = 1'b1; p_addr = AW'(5); p_data = ~shadow[5];      // R9
      end else if (i + 1 == 2 * (FT + 18 * HT)) begin
        p_we = 1'b1; p_addr = AW'(FBB); p_data = 8'h5A;         // R8 alias of byte 0
      end else if (i + 1 == 2 * (FT + 18 * HT) + 3) begin
        p_we = 1'b1; p_addr = AW'(FBB + 7); p_data = ~shadow[7]; // R8 alias of byte 7
      end else if (i + 1 == 2 * (FT + 19 * HT) + 1) begin
        p_we = 1'b1; p_addr = AW'(16383); p_data = ~shadow[FBB - 1]; // R8
      end else if (i + 1 == 2 * (FT + 20 * HT)) begin
        p_we = 1'b1; p_addr = AW'(10); p_data = 8'hC3;          // R8 in range
      end
      wr_en = p_we; wr_addr = p_addr; wr_data = p_data;
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule